// File: doc/BRIEF.md
# BCD Calendar Clock with Freeze

The block keeps the time of day and a century calendar, all in packed BCD: seconds, minutes, hours, date, day of week, month and two-digit year. A one-cycle pulse once per second advances the running counters. Software sees the time through a set of user copies behind a simple register bus with an address, write data, a write strobe and combinational read data. The user copies are refreshed from the running counters once per second.

A freeze bit in the control register stops the refresh of the user copies, so that software can read a consistent snapshot while the running counters keep counting. The same bit is used to set the clock. Fields written while the freeze bit is set are loaded into the running counters when the bit is cleared. Fields that were not written keep their running values. The control register also selects between 12-hour and 24-hour hour representation, and decides whether the clock keeps counting while the supply is in backup mode. A one-cycle update pulse tells a neighbouring alarm comparator that the counters have advanced.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, registers 0 to 6 read 00, 00, 00, 01, 01, 01, 00. Control register 7 reads 0x02. Any address from 8 to 15 reads 0x00.
- R2: The register map is: 0 seconds, 1 minutes, 2 hours, 3 date, 4 day of week, 5 month, 6 year, 7 control. Control bit 0 is freeze, bit 1 selects 24-hour mode when 1, and bit 2 keeps the clock running in backup mode when 1. Each enabled tick advances the time by one second. Seconds carry into minutes, minutes into hours and hours into the date, with every field kept in BCD.
- R3: The date wraps to 01 after the last day of the month. April, June, September and November have 30 days, the other months 31, and February has 29 days when the year is divisible by 4 and 28 otherwise. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R4: The day of week increments with each date change and wraps from 07 to 01.
- R5: The update pulse is high for exactly the one cycle after a sampled enabled tick. The user copies take the new time at the end of that cycle, so reads show it from the following cycle.
- R6: While freeze is 1, the user copies do not change except through writes, and the running counters keep advancing.
- R7: Freeze written during the cycle the update pulse is high still lets that cycle's refresh take place.
- R8: A write to registers 0 to 6 while freeze is 0 has no effect, and a write to addresses 8 to 15 has no effect.
- R9: Clearing freeze loads into the counters only the fields written while frozen. The other fields continue from their running values.
- R10: In 12-hour mode the hour reads 01 to 12 with bit 7 set for PM: midnight is 0x12, noon is 0x92 and 13:00 is 0x81. Hour writes made in 12-hour mode use the same encoding. The count goes from 11 AM to 12 PM, and from 11 PM to 12 AM, where the date increments.
- R11: When backup_mode is 1 and control bit 2 is 0, ticks are ignored and no update pulse is produced. When backup_mode is 0, ticks advance the clock whatever bit 2 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| backup_mode | input | 1 | Supply is running from backup |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| update_pulse | output | 1 | Counters advanced in the previous cycle |

## Verification
A running counter that carries wrongly stays invisible until the next refresh. It then shows up at reg_rdata two cycles after the tick that caused it. A field that carries wrongly can also hide while frozen, and only shows at the first refresh after release. The reference model is therefore compared on every cycle, so a refresh that is missing or comes early is seen within one cycle. Month-end, year-end, leap-year and 12-hour boundaries are loaded directly through the freeze path, so each of them becomes visible one tick after it is set.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NFIELD    = 7;
  localparam int F_SEC     = 0;
  localparam int F_MIN     = 1;
  localparam int F_HR      = 2;
  localparam int F_DATE    = 3;
  localparam int F_DOW     = 4;
  localparam int F_MON     = 5;
  localparam int F_YR      = 6;
  localparam int CTRL_ADDR = 7;
  localparam int C_FRZ     = 0;
  localparam int C_H24     = 1;
  localparam int C_RUNBK   = 2;

  typedef logic [NFIELD-1:0][7:0] cal_vec_t;

  // index 6 is the year, index 0 the seconds
  localparam cal_vec_t RESET_TIME = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    logic [6:0] t;
    t = v / 7'd10;
    return {t[3:0], 4'(v - t * 7'd10)};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [6:0] y;
    y = bcd2bin(yr);
    return y[1:0] == 2'b00;
  endfunction

  function automatic logic [4:0] days_in_month(input logic [7:0] mon, input logic [7:0] yr);
    case (bcd2bin(mon))
      7'd2:                      return is_leap(yr) ? 5'd29 : 5'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  // 24-hour BCD count to the visible hour code
  function automatic logic [7:0] hour_to_disp(input logic [7:0] h, input logic h24);
    logic [6:0] b;
    b = bcd2bin(h);
    if (h24)            return h;
    else if (b == 7'd0) return 8'h12;
    else if (b < 7'd12) return bin2bcd(b);
    else if (b == 7'd12) return 8'h92;
    else                return 8'h80 | bin2bcd(b - 7'd12);
  endfunction

  // visible hour code back to the 24-hour BCD count
  function automatic logic [7:0] disp_to_hour(input logic [7:0] v, input logic h24);
    logic [6:0] b;
    logic [6:0] h;
    b = bcd2bin({3'b000, v[4:0]});
    h = (b == 7'd12) ? 7'd0 : b;
    if (v[7]) h = h + 7'd12;
    return h24 ? v : bin2bcd(h);
  endfunction
endpackage

// File: rtl/cal_advance.sv
module cal_advance import cal_pkg::*; (
  input  cal_vec_t cur,
  output cal_vec_t nxt
);
  logic [6:0] s, m, h, d, w, mo, y;
  logic [4:0] dim;
  logic sec_wrap, min_wrap, day_wrap, date_wrap, mon_wrap;

  always_comb begin
    s   = bcd2bin(cur[F_SEC]);
    m   = bcd2bin(cur[F_MIN]);
    h   = bcd2bin(cur[F_HR]);
    d   = bcd2bin(cur[F_DATE]);
    w   = bcd2bin(cur[F_DOW]);
    mo  = bcd2bin(cur[F_MON]);
    y   = bcd2bin(cur[F_YR]);
    dim = days_in_month(cur[F_MON], cur[F_YR]);
    sec_wrap  = s >= 7'd59;
    min_wrap  = sec_wrap && (m >= 7'd59);
    day_wrap  = min_wrap && (h >= 7'd23);
    date_wrap = day_wrap && (d >= 7'(dim));
    mon_wrap  = date_wrap && (mo >= 7'd12);
    nxt = cur;
    nxt[F_SEC] = sec_wrap ? 8'h00 : bin2bcd(s + 7'd1);
    if (sec_wrap) nxt[F_MIN] = (m >= 7'd59) ? 8'h00 : bin2bcd(m + 7'd1);
    if (min_wrap) nxt[F_HR]  = (h >= 7'd23) ? 8'h00 : bin2bcd(h + 7'd1);
    if (day_wrap) begin
      nxt[F_DOW]  = (w >= 7'd7) ? 8'h01 : bin2bcd(w + 7'd1);
      nxt[F_DATE] = date_wrap ? 8'h01 : bin2bcd(d + 7'd1);
    end
    if (date_wrap) nxt[F_MON] = mon_wrap ? 8'h01 : bin2bcd(mo + 7'd1);
    if (mon_wrap)  nxt[F_YR]  = (y >= 7'd99) ? 8'h00 : bin2bcd(y + 7'd1);
  end
endmodule

// File: rtl/cal_counters.sv
module cal_counters import cal_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  cal_vec_t          adv_val,
  input  logic [NFIELD-1:0] load_mask,
  input  cal_vec_t          load_val,
  output cal_vec_t          cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= RESET_TIME;
    end else begin
      for (int i = 0; i < NFIELD; i++) begin
        if (load_mask[i])  cnt[i] <= load_val[i];
        else if (adv_en)   cnt[i] <= adv_val[i];
      end
    end
  end
endmodule

// File: rtl/cal_user_regs.sv
module cal_user_regs import cal_pkg::*; #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              refresh,
  input  cal_vec_t          cnt,
  output logic [7:0]        rdata,
  output cal_vec_t          copy,
  output logic              freeze,
  output logic              hr24,
  output logic              run_bk,
  output logic              release_ev,
  output logic [NFIELD-1:0] load_mask,
  output cal_vec_t          load_val
);
  localparam int IDX_W = $clog2(NFIELD);

  logic              ctrl_wr, field_wr;
  logic [IDX_W-1:0]  idx;
  logic [NFIELD-1:0] dirty;
  cal_vec_t          disp;

  assign idx        = addr[IDX_W-1:0];
  assign ctrl_wr    = we && (addr == ADDR_W'(CTRL_ADDR));
  assign field_wr   = we && (addr < ADDR_W'(NFIELD));
  assign release_ev = ctrl_wr && freeze && !wdata[C_FRZ];
  assign load_mask  = release_ev ? dirty : '0;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    if (i == F_HR) begin : g_hour
      assign disp[i]     = hour_to_disp(cnt[i], hr24);
      assign load_val[i] = disp_to_hour(copy[i], hr24);
    end else begin : g_plain
      assign disp[i]     = cnt[i];
      assign load_val[i] = copy[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy   <= RESET_TIME;
      dirty  <= '0;
      freeze <= 1'b0;
      hr24   <= 1'b1;
      run_bk <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        freeze <= wdata[C_FRZ];
        hr24   <= wdata[C_H24];
        run_bk <= wdata[C_RUNBK];
      end
      if (release_ev) begin
        dirty <= '0;
      end else if (field_wr && freeze) begin
        copy[idx]  <= wdata;
        dirty[idx] <= 1'b1;
      end
      if (refresh && !freeze) copy <= disp;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr < ADDR_W'(NFIELD))           rdata = copy[idx];
    else if (addr == ADDR_W'(CTRL_ADDR))  rdata = {5'b00000, run_bk, hr24, freeze};
  end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock import cal_pkg::*; #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              backup_mode,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  output logic              update_pulse
);
  logic              adv_en, adv_q;
  logic              freeze, hr24, run_bk, release_ev;
  logic [NFIELD-1:0] load_mask;
  cal_vec_t          cnt, adv_val, copy, load_val;

  assign adv_en       = tick_1hz && (!backup_mode || run_bk);
  assign update_pulse = adv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv_q <= 1'b0;
    else        adv_q <= adv_en;
  end

  cal_advance u_adv (
    .cur (cnt),
    .nxt (adv_val)
  );

  cal_counters u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_en    (adv_en),
    .adv_val   (adv_val),
    .load_mask (load_mask),
    .load_val  (load_val),
    .cnt       (cnt)
  );

  cal_user_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .refresh    (adv_q),
    .cnt        (cnt),
    .rdata      (reg_rdata),
    .copy       (copy),
    .freeze     (freeze),
    .hr24       (hr24),
    .run_bk     (run_bk),
    .release_ev (release_ev),
    .load_mask  (load_mask),
    .load_val   (load_val)
  );
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       backup_mode,
  input logic       update_pulse,
  input logic       run_bk,
  input logic       freeze,
  input logic       reg_we,
  input logic       release_ev,
  input logic [7:0] copy_sec,
  input logic [7:0] cnt_sec,
  input logic [7:0] cnt_min
);
  // R5: a pulse only ever follows a sampled tick
  a_r5_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> $past(tick_1hz));

  // R11: stopped in backup, a tick produces no pulse
  a_r11_backup_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && backup_mode && !run_bk) |=> !update_pulse);

  // R11: stopped in backup, the running seconds stay put
  a_r11_backup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (backup_mode && !run_bk && !release_ev) |=> $stable(cnt_sec));

  // R6: frozen copies hold without a write
  a_r6_frozen_copy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !reg_we) |=> $stable(copy_sec));

  // R2: second 59 carries into the minute
  a_r2_minute_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (update_pulse && !$past(release_ev) && $past(cnt_sec) == 8'h59)
      |-> (cnt_sec == 8'h00 && cnt_min != $past(cnt_min)));
endmodule

bind bcd_calendar_clock cal_clock_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_1hz     (tick_1hz),
  .backup_mode  (backup_mode),
  .update_pulse (update_pulse),
  .run_bk       (run_bk),
  .freeze       (freeze),
  .reg_we       (reg_we),
  .release_ev   (release_ev),
  .copy_sec     (copy[cal_pkg::F_SEC]),
  .cnt_sec      (cnt[cal_pkg::F_SEC]),
  .cnt_min      (cnt[cal_pkg::F_MIN])
);

// File: tb/bcd_calendar_clock_test.sv
`timescale 1ns/1ps
module bcd_calendar_clock_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       backup_mode = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       update_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  bit cb_h24 = 1'b1;
  bit cb_rb = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar_clock uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .backup_mode(backup_mode),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .update_pulse(update_pulse)
  );

  // ---------------- reference model ----------------
  int ms, mm, mh, md, mw, mo, my;
  logic [7:0] mcopy [7];
  bit mdirty [7];
  bit mfrz, m24, mrb, mpulse;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] show_hr(input int h, input bit h24);
    if (h24) return i2b(h);
    if (h == 0) return 8'h12;
    if (h < 12) return i2b(h);
    if (h == 12) return 8'h92;
    return 8'h80 | i2b(h - 12);
  endfunction

  function automatic int parse_hr(input logic [7:0] v, input bit h24);
    if (h24) return b2i(v);
    return (b2i({3'b000, v[4:0]}) % 12) + (v[7] ? 12 : 0);
  endfunction

  function automatic int mdays(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] mread(input logic [3:0] a);
    if (a < 4'd7) return mcopy[a];
    if (a == 4'd7) return {5'b00000, mrb, m24, mfrz};
    return 8'h00;
  endfunction

  task automatic madv();
    if (ms >= 59) begin
      ms = 0;
      if (mm >= 59) begin
        mm = 0;
        if (mh >= 23) begin
          mh = 0;
          mw = (mw >= 7) ? 1 : mw + 1;
          if (md >= mdays(mo, my)) begin
            md = 1;
            if (mo >= 12) begin mo = 1; my = (my >= 99) ? 0 : my + 1; end
            else mo++;
          end else md++;
        end else mh++;
      end else mm++;
    end else ms++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mm = 0; mh = 0; md = 1; mw = 1; mo = 1; my = 0;
      mcopy[0] = 8'h00; mcopy[1] = 8'h00; mcopy[2] = 8'h00; mcopy[3] = 8'h01;
      mcopy[4] = 8'h01; mcopy[5] = 8'h01; mcopy[6] = 8'h00;
      for (int i = 0; i < 7; i++) mdirty[i] = 1'b0;
      mfrz = 1'b0; m24 = 1'b1; mrb = 1'b0; mpulse = 1'b0;
    end else begin
      bit en;
      bit f;
      en = tick_1hz && (!backup_mode || mrb);
      f = mfrz;
      if (mpulse && !f) begin
        mcopy[0] = i2b(ms); mcopy[1] = i2b(mm); mcopy[2] = show_hr(mh, m24);
        mcopy[3] = i2b(md); mcopy[4] = i2b(mw); mcopy[5] = i2b(mo); mcopy[6] = i2b(my);
      end
      if (en) madv();
      if (reg_we) begin
        if (reg_addr == 4'd7) begin
          if (f && !reg_wdata[0]) begin
            if (mdirty[0]) ms = b2i(mcopy[0]);
            if (mdirty[1]) mm = b2i(mcopy[1]);
            if (mdirty[2]) mh = parse_hr(mcopy[2], m24);
            if (mdirty[3]) md = b2i(mcopy[3]);
            if (mdirty[4]) mw = b2i(mcopy[4]);
            if (mdirty[5]) mo = b2i(mcopy[5]);
            if (mdirty[6]) my = b2i(mcopy[6]);
            for (int i = 0; i < 7; i++) mdirty[i] = 1'b0;
          end
          mfrz = reg_wdata[0]; m24 = reg_wdata[1]; mrb = reg_wdata[2];
        end else if (reg_addr < 4'd7 && f) begin
          mcopy[reg_addr] = reg_wdata;
          mdirty[reg_addr] = 1'b1;
        end
      end
      mpulse = en;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (update_pulse !== mpulse) begin
        failures++;
        $display("FAIL %s update_pulse actual=%0b expected=%0b", cur_req, update_pulse, mpulse);
      end
      checks++;
      if (reg_rdata !== mread(reg_addr)) begin
        failures++;
        $display("FAIL %s rdata[%0d] actual=%02h expected=%02h", cur_req, reg_addr, reg_rdata, mread(reg_addr));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input bit frz);
    return {5'b00000, cb_rb, cb_h24, frz};
  endfunction

  task automatic tick1();
    tick_1hz = 1'b1; step(); tick_1hz = 1'b0; step(); step();
  endtask

  task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; #1;
    checks++;
    if (reg_rdata !== exp) begin
      failures++;
      $display("FAIL %s reg %0d actual=%02h expected=%02h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, d, w, mn, y);
    wr(4'd7, ctl(1'b1));
    wr(4'd0, s); wr(4'd1, mi); wr(4'd2, h); wr(4'd3, d);
    wr(4'd4, w); wr(4'd5, mn); wr(4'd6, y);
    wr(4'd7, ctl(1'b0));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    cur_req = "R1";
    chk(0, 8'h00, "R1"); chk(1, 8'h00, "R1"); chk(2, 8'h00, "R1"); chk(3, 8'h01, "R1");
    chk(4, 8'h01, "R1"); chk(5, 8'h01, "R1"); chk(6, 8'h00, "R1"); chk(7, 8'h02, "R1");
    chk(9, 8'h00, "R1");

    // R2 / R5 carries and refresh timing, R3 leap day, R4 weekday wrap
    cur_req = "R2";
    set_time(8'h58, 8'h59, 8'h23, 8'h28, 8'h07, 8'h02, 8'h24);
    reg_addr = 4'd0;
    tick_1hz = 1'b1; step(); tick_1hz = 1'b0;
    chk(0, 8'h58, "R5");
    step();
    chk(0, 8'h59, "R5");
    step();
    tick1();
    chk(0, 8'h00, "R2"); chk(1, 8'h00, "R2"); chk(2, 8'h00, "R2");
    chk(3, 8'h29, "R3"); chk(5, 8'h02, "R3"); chk(4, 8'h01, "R4");

    cur_req = "R3";
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h03, 8'h02, 8'h24);
    tick1();
    chk(3, 8'h01, "R3"); chk(5, 8'h03, "R3"); chk(4, 8'h04, "R4");
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h23);
    tick1();
    chk(3, 8'h01, "R3"); chk(5, 8'h03, "R3");
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h04, 8'h23);
    tick1();
    chk(3, 8'h01, "R3"); chk(5, 8'h05, "R3");
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h07, 8'h12, 8'h99);
    tick1();
    chk(6, 8'h00, "R3"); chk(5, 8'h01, "R3"); chk(3, 8'h01, "R3");
    chk(4, 8'h01, "R4"); chk(2, 8'h00, "R2");

    // R8 writes ignored while not frozen
    cur_req = "R8";
    wr(4'd1, 8'h33);
    wr(4'd10, 8'h55);
    chk(1, 8'h00, "R8"); chk(10, 8'h00, "R8");

    // R6 freeze holds copies, counters run
    cur_req = "R6";
    wr(4'd7, ctl(1'b1));
    tick1(); tick1(); tick1();
    chk(0, 8'h00, "R6");
    wr(4'd7, ctl(1'b0));
    chk(0, 8'h00, "R6");
    tick1();
    chk(0, 8'h04, "R6");

    // R7 freeze written in the refresh cycle
    cur_req = "R7";
    tick_1hz = 1'b1; step(); tick_1hz = 1'b0;
    wr(4'd7, ctl(1'b1));
    chk(0, 8'h05, "R7");
    tick1();
    chk(0, 8'h05, "R7");
    wr(4'd7, ctl(1'b0));
    tick1();
    chk(0, 8'h07, "R7");

    // R9 only written fields load
    cur_req = "R9";
    wr(4'd7, ctl(1'b1));
    wr(4'd1, 8'h42);
    tick1(); tick1();
    wr(4'd7, ctl(1'b0));
    tick1();
    chk(0, 8'h10, "R9"); chk(1, 8'h42, "R9"); chk(2, 8'h00, "R9");

    // R10 12-hour representation
    cur_req = "R10";
    cb_h24 = 1'b0;
    wr(4'd7, ctl(1'b0));
    set_time(8'h59, 8'h59, 8'h81, 8'h05, 8'h01, 8'h01, 8'h00);
    tick1();
    chk(2, 8'h82, "R10");
    set_time(8'h59, 8'h59, 8'h91, 8'h05, 8'h01, 8'h01, 8'h00);
    tick1();
    chk(2, 8'h12, "R10"); chk(3, 8'h06, "R10");
    set_time(8'h59, 8'h59, 8'h11, 8'h05, 8'h01, 8'h01, 8'h00);
    tick1();
    chk(2, 8'h92, "R10");
    set_time(8'h59, 8'h59, 8'h12, 8'h05, 8'h01, 8'h01, 8'h00);
    tick1();
    chk(2, 8'h01, "R10"); chk(3, 8'h05, "R10");
    cb_h24 = 1'b1;
    wr(4'd7, ctl(1'b0));
    tick1();
    chk(2, 8'h01, "R10"); chk(0, 8'h01, "R10");

    // R11 backup stop
    cur_req = "R11";
    backup_mode = 1'b1;
    tick1(); tick1();
    chk(0, 8'h01, "R11");
    cb_rb = 1'b1;
    wr(4'd7, ctl(1'b0));
    tick1();
    chk(0, 8'h02, "R11");
    backup_mode = 1'b0;
    cb_rb = 1'b0;
    wr(4'd7, ctl(1'b0));
    tick1();
    chk(0, 8'h03, "R11");
    step(); step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule